// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block sits behind a command decoder on the codec side of a serial audio link. Each command carries a 12-bit verb and a 16-bit payload. The block uses these commands to reach a 32-bit internal register space. The host cannot send a 32-bit value in one command. It therefore stages the target address and the write value in two 16-bit halves each. The upper half of the value launches the internal write.

A read takes two steps. A post verb starts a read of the address currently staged. The result lands in a holding register, and a separate fetch verb returns it. While an internal bus access is still open, every staging or post command is refused with a busy code. The host then has to resend that command. The internal side is a simple request/ready register bus: a strobe stays high until ready is seen.

Top module: `vbr_bridge`

## Requirements
- R1: After reset, no response is valid and both bus strobes are low. The staged address and value are zero, the read holding register is zero, and the status verb reports 0x00.
- R2: Verb 0x000 loads payload into address bits 15:0 and verb 0x100 loads address bits 31:16. The staged address drives the bus address output.
- R3: Verb 0x300 loads value bits 15:0. Verb 0x400 loads value bits 31:16 and starts a bus write of the full staged address and value. The write strobe, address and value hold until ready is sampled high.
- R4: Verb 0x702 starts a bus read of the staged address. The read strobe holds until ready is sampled high, and the bus read data is captured at that edge.
- R5: Verb 0xF01 returns 0x01 while a bus access is open and 0x00 otherwise.
- R6: While a bus access is open, verbs 0x000, 0x100, 0x300, 0x400 and 0x702 return 0x01 and change no staged register and start no access.
- R7: Verb 0xF03 returns the read holding register. The register keeps its value through writes and through refused or unknown verbs until the next read completes.
- R8: Every command is answered exactly once, on the clock edge that accepts it. Accepted staging and post verbs return 0x00.
- R9: Any other verb, for example 0x200, returns zero and changes nothing.
- R10: At most one access is open at a time, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_verb_i | input | 12 | Command verb |
| cmd_payload_i | input | 16 | Command payload |
| rsp_valid_o | output | 1 | Response valid |
| rsp_data_o | output | 32 | Response word |
| bus_addr_o | output | 32 | Internal bus address |
| bus_wdata_o | output | 32 | Internal bus write value |
| bus_we_o | output | 1 | Write strobe, held until ready |
| bus_re_o | output | 1 | Read strobe, held until ready |
| bus_rdata_i | input | 32 | Internal bus read data |
| bus_ready_i | input | 1 | Access completes at this edge |

## Verification
The bench runs full write and read sequences against a bus model with zero and three wait cycles. These runs show whether a result depends on when ready arrives. Commands sent back to back right after a launch hit the open-access window. There the staging, status, fetch and unknown verbs must each answer differently.

Two refused loads are checked later through the address of the next read and the value of the next write. This separates a correct refusal from a silent load. A read from a never-written location returns the inverted address. That tells a fresh capture apart from a stale holding register.

// File: rtl/vbr_pkg.sv
package vbr_pkg;
  localparam int VERB_W = 12;

  localparam logic [VERB_W-1:0] VERB_ADDR_LO = 12'h000;
  localparam logic [VERB_W-1:0] VERB_ADDR_HI = 12'h100;
  localparam logic [VERB_W-1:0] VERB_DATA_LO = 12'h300;
  localparam logic [VERB_W-1:0] VERB_DATA_HI = 12'h400;
  localparam logic [VERB_W-1:0] VERB_POST_RD = 12'h702;
  localparam logic [VERB_W-1:0] VERB_STATUS  = 12'hF01;
  localparam logic [VERB_W-1:0] VERB_RD_DATA = 12'hF03;

  localparam logic [7:0] ST_OK   = 8'h00;
  localparam logic [7:0] ST_BUSY = 8'h01;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_ADDR_LO,
    OP_ADDR_HI,
    OP_DATA_LO,
    OP_DATA_HI,
    OP_POST_RD,
    OP_STATUS,
    OP_RD_DATA
  } op_e;
endpackage

// File: rtl/vbr_decode.sv
module vbr_decode
  import vbr_pkg::*;
(
  input  logic              valid_i,
  input  logic [VERB_W-1:0] verb_i,
  output op_e               op_o,
  output logic              stage_o
);
  always_comb begin
    op_o = OP_NONE;
    if (valid_i) begin
      unique case (verb_i)
        VERB_ADDR_LO: op_o = OP_ADDR_LO;
        VERB_ADDR_HI: op_o = OP_ADDR_HI;
        VERB_DATA_LO: op_o = OP_DATA_LO;
        VERB_DATA_HI: op_o = OP_DATA_HI;
        VERB_POST_RD: op_o = OP_POST_RD;
        VERB_STATUS:  op_o = OP_STATUS;
        VERB_RD_DATA: op_o = OP_RD_DATA;
        default:      op_o = OP_NONE;
      endcase
    end
  end

  // verbs that busy can refuse
  assign stage_o = (op_o inside {OP_ADDR_LO, OP_ADDR_HI, OP_DATA_LO, OP_DATA_HI, OP_POST_RD});
endmodule

// File: rtl/vbr_stage.sv
module vbr_stage #(
  parameter int W      = 32,
  parameter int HALF_W = 16,
  localparam int NH    = W / HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NH-1:0]     ld_i,
  input  logic [HALF_W-1:0] half_i,
  output logic [W-1:0]      q_o
);
  for (genvar g = 0; g < NH; g++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_o[g*HALF_W +: HALF_W] <= '0;
      else if (ld_i[g]) q_o[g*HALF_W +: HALF_W] <= half_i;
    end
  end
endmodule

// File: rtl/vbr_bus_ctrl.sv
module vbr_bus_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_go_i,
  input  logic              rd_go_i,
  input  logic              bus_ready_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_we_o,
  output logic              bus_re_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] rd_hold_o
);
  assign busy_o = bus_we_o | bus_re_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_we_o  <= 1'b0;
      bus_re_o  <= 1'b0;
      rd_hold_o <= '0;
    end else if (busy_o) begin
      if (bus_ready_i) begin
        bus_we_o <= 1'b0;
        bus_re_o <= 1'b0;
        if (bus_re_o) rd_hold_o <= bus_rdata_i;
      end
    end else begin
      bus_we_o <= wr_go_i;
      bus_re_o <= rd_go_i & ~wr_go_i;
    end
  end
endmodule

// File: rtl/vbr_bridge.sv
module vbr_bridge
  import vbr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int RSP_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [11:0]       cmd_verb_i,
  input  logic [HALF_W-1:0] cmd_payload_i,
  output logic              rsp_valid_o,
  output logic [RSP_W-1:0]  rsp_data_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_we_o,
  output logic              bus_re_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ready_i
);
  localparam int NHA = ADDR_W / HALF_W;
  localparam int NHD = DATA_W / HALF_W;

  op_e  op;
  logic stage_op, busy, accept;
  logic [NHA-1:0]    ld_addr;
  logic [NHD-1:0]    ld_data;
  logic [DATA_W-1:0] rd_hold;
  logic [RSP_W-1:0]  rsp_d;

  vbr_decode u_dec (
    .valid_i (cmd_valid_i),
    .verb_i  (cmd_verb_i),
    .op_o    (op),
    .stage_o (stage_op)
  );

  assign accept = stage_op & ~busy;

  // half 0 for the low verb, half 1 for the high verb
  assign ld_addr = (accept && op inside {OP_ADDR_LO, OP_ADDR_HI})
                   ? (NHA'(1) << (op == OP_ADDR_HI)) : '0;
  assign ld_data = (accept && op inside {OP_DATA_LO, OP_DATA_HI})
                   ? (NHD'(1) << (op == OP_DATA_HI)) : '0;

  vbr_stage #(.W(ADDR_W), .HALF_W(HALF_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld_addr),
    .half_i (cmd_payload_i),
    .q_o    (bus_addr_o)
  );

  vbr_stage #(.W(DATA_W), .HALF_W(HALF_W)) u_data (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld_data),
    .half_i (cmd_payload_i),
    .q_o    (bus_wdata_o)
  );

  vbr_bus_ctrl #(.DATA_W(DATA_W)) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_go_i     (accept && op == OP_DATA_HI),
    .rd_go_i     (accept && op == OP_POST_RD),
    .bus_ready_i (bus_ready_i),
    .bus_rdata_i (bus_rdata_i),
    .bus_we_o    (bus_we_o),
    .bus_re_o    (bus_re_o),
    .busy_o      (busy),
    .rd_hold_o   (rd_hold)
  );

  always_comb begin
    rsp_d = '0;
    if (stage_op)                rsp_d = RSP_W'(busy ? ST_BUSY : ST_OK);
    else if (op == OP_STATUS)    rsp_d = RSP_W'(busy ? ST_BUSY : ST_OK);
    else if (op == OP_RD_DATA)   rsp_d = RSP_W'(rd_hold);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= cmd_valid_i;
      rsp_data_o  <= cmd_valid_i ? rsp_d : '0;
    end
  end
endmodule

// File: rtl/vbr_bridge_chk.sv
module vbr_bridge_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic [11:0] cmd_verb_i,
  input logic [15:0] cmd_payload_i,
  input logic        rsp_valid_o,
  input logic [31:0] rsp_data_o,
  input logic [31:0] bus_addr_o,
  input logic [31:0] bus_wdata_o,
  input logic        bus_we_o,
  input logic        bus_re_o,
  input logic [31:0] bus_rdata_i,
  input logic        bus_ready_i
);
  p_one_rsp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rsp_valid_o);
  p_no_rsp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !rsp_valid_o);
  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o));
  p_wr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && !bus_ready_i) |=> (bus_we_o && $stable(bus_addr_o) && $stable(bus_wdata_o)));
  p_rd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_o && !bus_ready_i) |=> bus_re_o);
  p_addr_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o || bus_re_o) |=> $stable(bus_addr_o));
  p_busy_rsp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (bus_we_o || bus_re_o) && cmd_verb_i == 12'h000) |=> rsp_data_o == 32'h1);
  p_unknown_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_verb_i == 12'h200) |=> rsp_data_o == 32'h0);
endmodule

bind vbr_bridge vbr_bridge_chk u_chk (.*);

// File: tb/vbr_bridge_test.sv
module vbr_bridge_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [11:0] cmd_verb_i = '0;
  logic [15:0] cmd_payload_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_data_o;
  logic [31:0] bus_addr_o, bus_wdata_o;
  logic        bus_we_o, bus_re_o;
  logic [31:0] bus_rdata_i = '0;
  logic        bus_ready_i = 1'b0;

  int n_tests = 0, n_fail = 0;
  int wait_cycles = 3, wcnt = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [31:0] last_wr_addr = '0, last_wr_data = '0, last_rd_addr = '1;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk_i = ~clk_i;

  vbr_bridge uut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] verb, input logic [15:0] pl, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    cmd_valid_i   = 1'b1;
    cmd_verb_i    = verb;
    cmd_payload_i = pl;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  // response monitor
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected response", rsp_data_o, '0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rsp_data_o === e, t, rsp_data_o, e);
      end
    end
  end

  // bus model: ready after wait_cycles strobe cycles
  always @(negedge clk_i) begin
    if (bus_we_o || bus_re_o) begin
      bus_ready_i = (wcnt == wait_cycles);
      wcnt++;
      bus_rdata_i = mem.exists(bus_addr_o) ? mem[bus_addr_o] : ~bus_addr_o;
      if (bus_ready_i) begin
        if (bus_we_o) begin
          wr_cnt++; last_wr_addr = bus_addr_o; last_wr_data = bus_wdata_o;
          mem[bus_addr_o] = bus_wdata_o;
        end else begin
          rd_cnt++; last_rd_addr = bus_addr_o;
        end
      end
    end else begin
      bus_ready_i = 1'b0;
      wcnt = 0;
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        check(rsp_valid_o == 1'b0 && bus_we_o == 1'b0 && bus_re_o == 1'b0, "R1 reset outputs",
              {rsp_valid_o, bus_we_o, bus_re_o}, '0);
        check(bus_addr_o == '0 && bus_wdata_o == '0, "R1 staged regs zero", bus_addr_o | bus_wdata_o, '0);
        rst_ni = 1'b1;
        send(12'hF01, 0, 32'h0, "R1 status after reset");
        send(12'hF03, 0, 32'h0, "R1 holding reg after reset");
        send(12'h702, 0, 32'h0, "R8 post accepted");
        idle(8);
        check(last_rd_addr == 32'h0, "R1 read of reset address", last_rd_addr, 32'h0);
        send(12'hF03, 0, 32'hFFFF_FFFF, "R4 read captured");

        send(12'h000, 16'h1234, 32'h0, "R2 addr low");
        send(12'h100, 16'hABCD, 32'h0, "R2 addr high");
        send(12'h300, 16'h5678, 32'h0, "R3 data low");
        send(12'h400, 16'h9ABC, 32'h0, "R3 data high launches");
        send(12'h000, 16'hFFFF, 32'h1, "R6 addr refused busy");
        send(12'hF01, 0, 32'h1, "R5 status busy");
        send(12'h200, 16'h5555, 32'h0, "R9 unknown during busy");
        send(12'hF03, 0, 32'hFFFF_FFFF, "R7 fetch during busy");
        idle(10);
        check(wr_cnt == 1, "R3 one write", wr_cnt, 1);
        check(last_wr_addr == 32'hABCD_1234, "R3 write address", last_wr_addr, 32'hABCD_1234);
        check(last_wr_data == 32'h9ABC_5678, "R3 write data", last_wr_data, 32'h9ABC_5678);
        send(12'hF01, 0, 32'h0, "R5 status idle");
        send(12'hF03, 0, 32'hFFFF_FFFF, "R7 hold across write");
        send(12'h702, 0, 32'h0, "R4 post");
        idle(10);
        check(last_rd_addr == 32'hABCD_1234, "R6 address untouched by refused load", last_rd_addr, 32'hABCD_1234);
        send(12'hF03, 0, 32'h9ABC_5678, "R4 readback");

        wait_cycles = 0;
        send(12'h300, 16'h0001, 32'h0, "R3 data low");
        send(12'h400, 16'h0002, 32'h0, "R3 data high zero wait");
        send(12'h300, 16'h7777, 32'h1, "R6 data refused zero wait");
        idle(4);
        check(last_wr_data == 32'h0002_0001, "R3 zero wait write", last_wr_data, 32'h0002_0001);
        send(12'h400, 16'h0003, 32'h0, "R3 relaunch");
        idle(4);
        check(last_wr_data == 32'h0003_0001, "R6 data low untouched", last_wr_data, 32'h0003_0001);
        check(wr_cnt == 3, "R10 write count", wr_cnt, 3);

        send(12'h7FF, 16'h1111, 32'h0, "R9 unknown verb");
        send(12'h200, 16'h2222, 32'h0, "R9 unknown verb 0x200");
        idle(4);
        check(wr_cnt == 3 && rd_cnt == 2, "R9 no access started", wr_cnt + rd_cnt, 5);
        check(bus_addr_o == 32'hABCD_1234, "R9 address unchanged", bus_addr_o, 32'hABCD_1234);
        send(12'hF03, 0, 32'h9ABC_5678, "R7 hold after unknown");

        send(12'h000, 16'h0010, 32'h0, "R2 addr low");
        send(12'h100, 16'h0000, 32'h0, "R2 addr high");
        send(12'h702, 0, 32'h0, "R4 post new address");
        send(12'h702, 0, 32'h1, "R6 post refused");
        idle(4);
        check(rd_cnt == 3, "R10 single read", rd_cnt, 3);
        send(12'hF03, 0, 32'hFFFF_FFEF, "R4 fresh capture");
        idle(3);
        check(exp_q.size() == 0, "R8 all answered", exp_q.size(), 0);
      end
      begin
        repeat (5000) @(posedge clk_i);
        check(1'b0, "watchdog expired", 0, 0);
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule